// File: doc/BRIEF.md
# Serial Bit-Rate Timing Generator

This block produces the timing pulses for an asynchronous serial port. A CPU writes one byte-wide rate control register. The block divides its clock, which is the processor bus clock at one quarter of the crystal frequency, in two cascaded stages. The first stage is a prescaler that divides by 1, 3, 4 or 13. The second stage is a power-of-two divider set by a 3-bit exponent. The output of the second stage is a one-cycle oversampling pulse (`os_tick`) for the receiver's sampler. A further divide by the oversampling ratio (16 by default) gives the one-cycle bit pulse (`bit_tick`).

The register can be read back at any time. It also stores two test-control bits that have no effect on timing. On reset the register is cleared, so the divisor is 1. If the mode pins select bootstrap operation while reset is held, the register is preset to 8'h33 instead. Any write restarts both divider stages, so the first pulse after a write always comes after a full period.

Top module: `sci_rate_gen`

## Requirements
- R1: A reset with bootstrap not selected sets the register to 8'h00. The read value is 8'h00 and `os_tick` is high in every cycle.
- R2: A reset with `mode_special`=1 and `mode_a`=0 sets the register to 8'h33. The read value is 8'h33, the prescale is 13 and the exponent is 3. The first `os_tick` comes in the 104th cycle after reset is released, counting the release cycle as the first. Any other mode-pin combination gives the R1 value.
- R3: `rd_data` returns the stored register with bit 6 forced to 0. Bit 7 (test clear) and bit 3 (clock check) are stored and read back. They do not change the tick timing.
- R4: Register bits 5:4 select the prescale: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R5: Register bits 2:0 hold the exponent n. The `os_tick` period is D = prescale × 2^n cycles.
- R6: `bit_tick` is high once in every OS_RATIO `os_tick` pulses, and only in a cycle where `os_tick` is also high. Its period is OS_RATIO × D cycles.
- R7: A write restarts both dividers. Counting the cycle after the write edge as cycle 1, the first `os_tick` is in cycle D and the first `bit_tick` is in cycle OS_RATIO × D.
- R8: When D > 1, `os_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (crystal / 4) |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_special | input | 1 | Special operating mode pin, sampled during reset |
| mode_a | input | 1 | Mode-A pin, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read-back value |
| os_tick | output | 1 | One-cycle oversampling pulse |
| bit_tick | output | 1 | One-cycle bit-rate pulse |

## Verification
After a write, the read-back value is due in the first cycle. The first oversampling pulse is due in cycle D and the first bit pulse in cycle 16·D, where the cycle after the write edge is cycle 1. After reset, the cycle in which reset is released counts as cycle 1. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the write or from the reset release, and compares the cycle of each first pulse with D computed arithmetically. It does this for all 32 prescale and exponent combinations. It also checks a mid-period rewrite and both reset presets.

// File: rtl/sci_rate_pkg.sv
package sci_rate_pkg;
   localparam int REG_W    = 8;
   localparam int SEL_LO   = 4;
   localparam int EXP_W    = 3;
   localparam int PRE_W    = 4;
   localparam int POW_W    = (1 << EXP_W) - 1;
   localparam int DIV_W    = PRE_W + POW_W;
   localparam logic [REG_W-1:0] RD_MASK = 8'hBF;

   // prescale map: 00->1, 01->3, 10->4, 11->13
   function automatic logic [PRE_W-1:0] prescale_div(input logic [1:0] sel);
      case (sel)
         2'b00:   prescale_div = PRE_W'(1);
         2'b01:   prescale_div = PRE_W'(3);
         2'b10:   prescale_div = PRE_W'(4);
         default: prescale_div = PRE_W'(13);
      endcase
   endfunction
endpackage

// File: rtl/sci_prescaler.sv
module sci_prescaler
   import sci_rate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [1:0] sel,
   output logic       pre_tick
);
   logic [PRE_W-1:0] cnt;
   logic [PRE_W-1:0] limit;

   assign limit    = prescale_div(sel) - PRE_W'(1);
   assign pre_tick = (cnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cnt <= '0;
      else if (pre_tick)     cnt <= '0;
      else                   cnt <= cnt + PRE_W'(1);
   end

   // R4
   pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= limit);
endmodule

// File: rtl/sci_pow2_div.sv
module sci_pow2_div
   import sci_rate_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             adv,
   input  logic [EXP_W-1:0] expo,
   output logic             out_tick
);
   logic [POW_W-1:0] cnt;
   logic [POW_W-1:0] mask;

   assign mask     = ~({POW_W{1'b1}} << expo);
   assign out_tick = adv && (cnt == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) cnt <= '0;
      else if (adv) begin
         if (cnt == mask) cnt <= '0;
         else             cnt <= cnt + POW_W'(1);
      end
   end

   // R5
   pow_range_chk: assert property (@(posedge clk) disable iff (!rst_n || restart)
      cnt <= mask);
endmodule

// File: rtl/sci_os_div.sv
module sci_os_div #(
   parameter int RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic os_in,
   output logic bit_out
);
   localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

   initial ratio_param_chk: assert (RATIO >= 1 && (RATIO & (RATIO - 1)) == 0)
      else $error("RATIO must be a power of two");

   generate
      if (RATIO == 1) begin : g_pass
         assign bit_out = os_in;
      end else begin : g_count
         logic [CW-1:0] cnt;
         assign bit_out = os_in && (cnt == CW'(RATIO - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || restart) cnt <= '0;
            else if (os_in)        cnt <= cnt + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/sci_rate_gen.sv
module sci_rate_gen
   import sci_rate_pkg::*;
#(
   parameter int               OS_RATIO   = 16,
   parameter logic [REG_W-1:0] BOOT_VALUE = 8'h33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_special,
   input  logic             mode_a,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             os_tick,
   output logic             bit_tick
);
   logic [REG_W-1:0] ctrl_q;
   logic             boot_sel;
   logic             pre_tick;
   logic [1:0]       sel;
   logic [EXP_W-1:0] expo;

   assign boot_sel = mode_special && !mode_a;
   assign sel      = ctrl_q[SEL_LO +: 2];
   assign expo     = ctrl_q[EXP_W-1:0];
   assign rd_data  = ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     ctrl_q <= boot_sel ? (BOOT_VALUE & RD_MASK) : '0;
      else if (wr_en) ctrl_q <= wr_data & RD_MASK;
   end

   sci_prescaler u_pre (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .sel(sel), .pre_tick(pre_tick)
   );

   sci_pow2_div u_pow (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .adv(pre_tick),
      .expo(expo), .out_tick(os_tick)
   );

   sci_os_div #(.RATIO(OS_RATIO)) u_osd (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .os_in(os_tick), .bit_out(bit_tick)
   );

   logic [DIV_W-1:0] div_total;
   assign div_total = DIV_W'(prescale_div(sel)) << expo;

   // R6
   bit_needs_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> os_tick);

   // R7
   restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (os_tick == (div_total == DIV_W'(1))));

   // R8
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (os_tick && !wr_en && div_total != DIV_W'(1)) |=> !os_tick);

   // R3
   readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == ($past(wr_data) & RD_MASK)));
endmodule

// File: tb/sci_rate_gen_tb.sv
module sci_rate_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int OSR        = 16;
   localparam int WATCHDOG   = 195000;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       mode_special = 0;
   logic       mode_a = 0;
   logic       wr_en = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] rd_data;
   logic       os_tick, bit_tick;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sci_rate_gen #(.OS_RATIO(OSR)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_special(mode_special), .mode_a(mode_a),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .os_tick(os_tick), .bit_tick(bit_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int pre_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 3;
         2'd2: return 4;
         default: return 13;
      endcase
   endfunction

   // caller stands at the first falling edge (cycle 1) after write or reset release
   task automatic measure(input int d, input string tag);
      int first_os = 0, first_bit = 0, os_cnt = 0, os_at_bit = 0;
      int back2back = 0, orphan = 0;
      bit prev_os = 0;
      for (int c = 1; c <= OSR * d; c++) begin
         if (c > 1) @(negedge clk);
         if (os_tick) begin
            os_cnt++;
            if (first_os == 0) first_os = c;
            if (prev_os && d > 1) back2back++;
         end
         if (bit_tick) begin
            if (!os_tick) orphan++;
            if (first_bit == 0) begin first_bit = c; os_at_bit = os_cnt; end
         end
         prev_os = os_tick;
      end
      check(first_os == d, {tag, " R5 R7 first os_tick"}, first_os, d);
      check(first_bit == OSR * d, {tag, " R6 R7 first bit_tick"}, first_bit, OSR * d);
      check(os_at_bit == OSR, {tag, " R6 os ticks per bit"}, os_at_bit, OSR);
      check(orphan == 0, {tag, " R6 bit without os"}, orphan, 0);
      check(back2back == 0, {tag, " R8 consecutive os_tick"}, back2back, 0);
   endtask

   task automatic write_reg(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1; wr_data = v;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic do_reset(input bit sp, input bit ma);
      @(negedge clk);
      rst_n = 0; mode_special = sp; mode_a = ma;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      // R1: plain reset
      do_reset(0, 0);
      check(rd_data == 8'h00, "R1 reset value", rd_data, 0);
      measure(1, "R1 reset D=1");

      // R4 R5: full sweep of prescale and exponent
      for (int s = 0; s < 4; s++) begin
         for (int n = 0; n < 8; n++) begin
            logic [7:0] v;
            v = 8'((s << 4) | n);
            write_reg(v);
            check(rd_data == v, "R3 R4 sweep readback", rd_data, v);
            measure(pre_of(2'(s)) << n, "R4 R5 sweep");
         end
      end

      // R3: bit 6 dropped, bits 7 and 3 stored, timing unaffected (prescale 1, n=1)
      write_reg(8'hC9);
      check(rd_data == 8'h89, "R3 test bits readback", rd_data, 8'h89);
      measure(2, "R3 test bits");

      // R7: rewrite midway through a period restarts the count
      write_reg(8'h32);
      repeat (30) @(negedge clk);
      write_reg(8'h32);
      measure(52, "R7 mid-period rewrite");

      // R2: special mode with mode_a set is not bootstrap
      do_reset(1, 1);
      check(rd_data == 8'h00, "R2 non-boot mode value", rd_data, 0);

      // R2: bootstrap preset
      do_reset(1, 0);
      check(rd_data == 8'h33, "R2 boot value", rd_data, 8'h33);
      measure(104, "R2 boot timing");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule